// File: doc/BRIEF.md
# Processor Core Timer Unit

This block supplies the three time-driven event sources of an embedded processor core. A 64-bit timebase counts up by one on each cycle that the tick enable is high. A down-counting decrementer, a fixed-interval timer and a watchdog all run from that tick. The fixed-interval timer and the watchdog raise an event when a selected timebase bit changes from 0 to 1. The selected bit comes either from a 6-bit code held in the control register (extended mode) or from a four-entry tap table fixed at elaboration (table mode).

Software reaches four 32-bit registers through a single-cycle write port and a combinational read port: a control word, a status word with write-one-to-clear semantics, the live decrementer and the decrementer reload value. Each of the three level interrupt outputs is its status flag gated by its enable bit. The watchdog steps through an arm, then interrupt, then reset escalation. On the final step it emits a one-cycle reset request together with a 2-bit reset code.

Top module: `cpu_timer_unit`

## Requirements
- R1: After reset the control, status, decrementer and reload registers read as zero, the timebase is zero, and all interrupt and reset-request outputs are low.
- R2: A write to the status register (address 1) clears exactly the status bits written as 1 and leaves the others unchanged. In a cycle where an event sets a bit that the same write clears, the set wins.
- R3: Each interrupt output is high exactly while its status flag and its enable bit are both set, so a change of an enable bit shows on the output in the cycle after the control write. The status flags are decrementer (bit 27), fixed-interval (bit 26) and watchdog (bit 30). The enable bits are decrementer (control bit 26), fixed-interval (control bit 23) and watchdog (control bit 27).
- R4: The decrementer (address 2) decrements once per tick while nonzero. The tick that takes it from 1 to 0 sets status bit 27. With auto-reload (control bit 22) off it then holds at 0 and raises no further events. A register write to it takes priority over that cycle's tick.
- R5: With auto-reload on, the tick that would take the decrementer from 1 to 0 sets status bit 27 and loads the reload register (address 3) instead.
- R6: In extended mode the fixed-interval timer sets status bit 26 on the tick where timebase bit {control[16:13], control[25:24]} goes from 0 to 1. The watchdog uses bit {control[20:17], control[31:30]}.
- R7: In table mode the 2-bit period select (control[25:24] for the fixed-interval timer, control[31:30] for the watchdog) indexes a four-entry parameter table of timebase bit positions.
- R8: On a watchdog event: if status bit 31 is clear it is set. Otherwise, if status bit 30 is clear it is set. Otherwise the reset control field control[29:28] is copied into status[29:28] and the reset request pulses high for one cycle, with the reset code output equal to status[29:28].
- R9: When the reset control field is zero, a watchdog event with status bits 31 and 30 already set changes no status bit and raises no reset request.
- R10: In table mode the extension fields control[20:13] are not stored and read as zero. In extended mode they read back as written. Control bits 21 and 12:0 always read as zero.
- R11: The timebase advances by exactly one on each cycle with the tick enable high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase advance enable, one tick per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 decrementer, 3 reload |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| tb_o | output | TB_W (64) | Current timebase value |
| irq_dec | output | 1 | Decrementer interrupt level |
| irq_fit | output | 1 | Fixed-interval interrupt level |
| irq_wdt | output | 1 | Watchdog interrupt level |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| wdt_rst_code | output | 2 | Watchdog reset status code |

## Verification
Two instances, one per tap mode, are driven from the same bus. For each tapped timer the bench works out from the timebase how many ticks remain until the chosen bit rises, then checks that the flag is still clear one tick before and set on that tick. A wrong tap position or a level-triggered event therefore shows up. The decrementer is run with auto-reload off and on, which separates holding at zero from reloading. The watchdog is driven through three successive events, with a nonzero and then a zero reset-control field, to confirm the order of the escalation and that a zero field suppresses the reset.

// File: rtl/ctu_pkg.sv
`timescale 1ns/1ps
package ctu_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_STAT   = 2'd1,
        REG_DEC    = 2'd2,
        REG_RELOAD = 2'd3
    } ctu_reg_e;

    // Control word field positions
    localparam int C_WP_LO  = 30;
    localparam int C_WRC_LO = 28;
    localparam int C_WIE    = 27;
    localparam int C_DIE    = 26;
    localparam int C_FP_LO  = 24;
    localparam int C_FIE    = 23;
    localparam int C_ARE    = 22;
    localparam int C_WPX_LO = 17;
    localparam int C_FPX_LO = 13;

    localparam logic [31:0] CTRL_BASE_MASK = 32'hFFC0_0000;
    localparam logic [31:0] CTRL_EXT_MASK  = 32'h001F_E000;

    // Status flags, packed so that they map onto word bits 31:26
    typedef struct packed {
        logic       enw;
        logic       wis;
        logic [1:0] wrs;
        logic       dis;
        logic       fis;
    } ctu_stat_t;

endpackage

// File: rtl/ctu_tap_event.sv
`timescale 1ns/1ps
// Detects a 0-to-1 transition of a selected timebase bit on a tick.
module ctu_tap_event #(
    parameter int          TB_W     = 64,
    parameter bit          EXT_MODE = 1'b1,
    parameter logic [23:0] TAPS     = 24'd0
) (
    input  logic [TB_W-1:0] tb,
    input  logic            tick,
    input  logic [1:0]      period,
    input  logic [3:0]      ext,
    output logic            fire
);
    localparam logic [TB_W-1:0] ONE = TB_W'(1);

    logic [5:0]      idx;
    logic [TB_W-1:0] sel;
    logic [TB_W-1:0] tb_inc;

    generate
        if (EXT_MODE) begin : g_ext
            assign idx = {ext, period};
        end else begin : g_tab
            logic unused_ext;
            assign unused_ext = ^ext;
            assign idx = TAPS[period*6 +: 6];
        end
    endgenerate

    always_comb begin
        sel    = ONE << idx;
        tb_inc = tb + ONE;
        fire   = tick && ((tb & sel) == '0) && ((tb_inc & sel) != '0);
    end
endmodule

// File: rtl/ctu_decrementer.sv
`timescale 1ns/1ps
// Next-value logic of the down counter with optional reload.
module ctu_decrementer #(
    parameter int DEC_W = 32
) (
    input  logic [DEC_W-1:0] dec_q,
    input  logic             tick,
    input  logic             auto_reload,
    input  logic [DEC_W-1:0] reload,
    input  logic             load,
    input  logic [DEC_W-1:0] load_val,
    output logic [DEC_W-1:0] dec_d,
    output logic             zero_hit
);
    localparam logic [DEC_W-1:0] ONE = DEC_W'(1);

    always_comb begin
        dec_d    = dec_q;
        zero_hit = 1'b0;
        if (load) begin
            dec_d = load_val;
        end else if (tick && (dec_q != '0)) begin
            zero_hit = (dec_q == ONE);
            if (zero_hit && auto_reload) begin
                dec_d = reload;
            end else begin
                dec_d = dec_q - ONE;
            end
        end
    end
endmodule

// File: rtl/ctu_wdt_seq.sv
`timescale 1ns/1ps
// Watchdog escalation: arm, then interrupt, then reset.
module ctu_wdt_seq
    import ctu_pkg::*;
(
    input  logic      fire,
    input  ctu_stat_t stat_in,
    input  logic [1:0] rst_ctl,
    output ctu_stat_t stat_out,
    output logic      rst_pulse
);
    always_comb begin
        stat_out  = stat_in;
        rst_pulse = 1'b0;
        if (fire) begin
            if (!stat_in.enw) begin
                stat_out.enw = 1'b1;
            end else if (!stat_in.wis) begin
                stat_out.wis = 1'b1;
            end else if (rst_ctl != 2'd0) begin
                stat_out.wrs = rst_ctl;
                rst_pulse    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpu_timer_unit.sv
`timescale 1ns/1ps
module cpu_timer_unit
    import ctu_pkg::*;
#(
    parameter int          TB_W     = 64,
    parameter int          DEC_W    = 32,
    parameter bit          EXT_MODE = 1'b1,
    parameter logic [23:0] FIT_TAPS = {6'd21, 6'd17, 6'd13, 6'd9},
    parameter logic [23:0] WDT_TAPS = {6'd33, 6'd29, 6'd25, 6'd21}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic [TB_W-1:0] tb_o,
    output logic            irq_dec,
    output logic            irq_fit,
    output logic            irq_wdt,
    output logic            wdt_rst_req,
    output logic [1:0]      wdt_rst_code
);
    localparam logic [31:0] CTRL_MASK = EXT_MODE ? (CTRL_BASE_MASK | CTRL_EXT_MASK)
                                                 : CTRL_BASE_MASK;
    localparam logic [TB_W-1:0] TB_ONE = TB_W'(1);

    typedef struct packed {
        logic [31:0]      ctrl;
        ctu_stat_t        stat;
        logic [DEC_W-1:0] dec;
        logic [DEC_W-1:0] reload;
        logic [TB_W-1:0]  tb;
        logic             rst_req;
    } state_t;

    state_t s_q, s_d;

    logic             wr_ctrl, wr_stat, wr_dec, wr_rel;
    logic             fit_fire, wdt_fire, dec_hit, wdt_pulse;
    logic [DEC_W-1:0] dec_next;
    ctu_stat_t        stat_clr, stat_wdt;

    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);
        wr_stat  = reg_wr && (reg_addr == REG_STAT);
        wr_dec   = reg_wr && (reg_addr == REG_DEC);
        wr_rel   = reg_wr && (reg_addr == REG_RELOAD);
        stat_clr = s_q.stat & ~(wr_stat ? ctu_stat_t'(reg_wdata[31:26]) : ctu_stat_t'(6'd0));
    end

    ctu_tap_event #(.TB_W(TB_W), .EXT_MODE(EXT_MODE), .TAPS(FIT_TAPS)) u_fit_tap (
        .tb     (s_q.tb),
        .tick   (tick_en),
        .period (s_q.ctrl[C_FP_LO +: 2]),
        .ext    (s_q.ctrl[C_FPX_LO +: 4]),
        .fire   (fit_fire)
    );

    ctu_tap_event #(.TB_W(TB_W), .EXT_MODE(EXT_MODE), .TAPS(WDT_TAPS)) u_wdt_tap (
        .tb     (s_q.tb),
        .tick   (tick_en),
        .period (s_q.ctrl[C_WP_LO +: 2]),
        .ext    (s_q.ctrl[C_WPX_LO +: 4]),
        .fire   (wdt_fire)
    );

    ctu_decrementer #(.DEC_W(DEC_W)) u_dec (
        .dec_q       (s_q.dec),
        .tick        (tick_en),
        .auto_reload (s_q.ctrl[C_ARE]),
        .reload      (s_q.reload),
        .load        (wr_dec),
        .load_val    (reg_wdata[DEC_W-1:0]),
        .dec_d       (dec_next),
        .zero_hit    (dec_hit)
    );

    ctu_wdt_seq u_wseq (
        .fire      (wdt_fire),
        .stat_in   (stat_clr),
        .rst_ctl   (s_q.ctrl[C_WRC_LO +: 2]),
        .stat_out  (stat_wdt),
        .rst_pulse (wdt_pulse)
    );

    always_comb begin
        s_d         = s_q;
        s_d.tb      = tick_en ? (s_q.tb + TB_ONE) : s_q.tb;
        s_d.dec     = dec_next;
        s_d.stat    = stat_wdt;
        s_d.rst_req = wdt_pulse;
        if (dec_hit)  s_d.stat.dis = 1'b1;
        if (fit_fire) s_d.stat.fis = 1'b1;
        if (wr_ctrl)  s_d.ctrl     = reg_wdata & CTRL_MASK;
        if (wr_rel)   s_d.reload   = reg_wdata[DEC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = s_q.ctrl;
            REG_STAT: reg_rdata = {s_q.stat, 26'd0};
            REG_DEC:  reg_rdata = 32'(s_q.dec);
            default:  reg_rdata = 32'(s_q.reload);
        endcase
    end

    assign tb_o         = s_q.tb;
    assign irq_dec      = s_q.stat.dis && s_q.ctrl[C_DIE];
    assign irq_fit      = s_q.stat.fis && s_q.ctrl[C_FIE];
    assign irq_wdt      = s_q.stat.wis && s_q.ctrl[C_WIE];
    assign wdt_rst_req  = s_q.rst_req;
    assign wdt_rst_code = s_q.stat.wrs;

endmodule

// File: rtl/ctu_checker.sv
`timescale 1ns/1ps
module ctu_checker #(
    parameter int TB_W  = 64,
    parameter int DEC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_en,
    input logic            reg_wr,
    input logic [1:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic [TB_W-1:0] tb_o,
    input logic            irq_dec,
    input logic            wdt_rst_req,
    input logic [1:0]      wdt_rst_code,
    input logic [DEC_W-1:0] dec_q,
    input logic            are
);
    p_tb_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (tb_o == $past(tb_o) + TB_W'(1)));

    p_tb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tb_o));

    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    p_rst_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> (wdt_rst_code != 2'd0));

    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[27] && !tick_en) |=> !irq_dec);

    p_dec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q == '0 && !are && !(reg_wr && reg_addr == 2'd2)) |=> (dec_q == '0));
endmodule

bind cpu_timer_unit ctu_checker #(.TB_W(TB_W), .DEC_W(DEC_W)) u_ctu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .tb_o         (tb_o),
    .irq_dec      (irq_dec),
    .wdt_rst_req  (wdt_rst_req),
    .wdt_rst_code (wdt_rst_code),
    .dec_q        (s_q.dec),
    .are          (s_q.ctrl[22])
);

// File: tb/cpu_timer_unit_bench.sv
`timescale 1ns/1ps
module cpu_timer_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;

    logic [31:0] rd_x, rd_t;
    logic [63:0] tb_x, tb_t;
    logic irqd_x, irqf_x, irqw_x, rq_x;
    logic irqd_t, irqf_t, irqw_t, rq_t;
    logic [1:0] code_x, code_t;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    cpu_timer_unit #(.EXT_MODE(1'b1)) u_cpu_timer_unit (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_x), .tb_o(tb_x),
        .irq_dec(irqd_x), .irq_fit(irqf_x), .irq_wdt(irqw_x),
        .wdt_rst_req(rq_x), .wdt_rst_code(code_x)
    );

    cpu_timer_unit #(
        .EXT_MODE(1'b0),
        .FIT_TAPS({6'd5, 6'd4, 6'd3, 6'd1}),
        .WDT_TAPS({6'd9, 6'd8, 6'd7, 6'd6})
    ) u_cpu_timer_unit_tab (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_t), .tb_o(tb_t),
        .irq_dec(irqd_t), .irq_fit(irqf_t), .irq_wdt(irqw_t),
        .wdt_rst_req(rq_t), .wdt_rst_code(code_t)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] vx, output logic [31:0] vt);
        @(negedge clk);
        reg_addr = a;
        #1;
        vx = rd_x;
        vt = rd_t;
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    function automatic int to_rise(input logic [63:0] tb, input int k);
        logic [63:0] c;
        logic [63:0] nx;
        int n;
        c = tb;
        n = 1;
        nx = c + 64'd1;
        while (!(c[k] == 1'b0 && nx[k] == 1'b1)) begin
            c = nx;
            nx = c + 64'd1;
            n++;
        end
        return n;
    endfunction

    task automatic t_reset;
        logic [31:0] vx, vt;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), vx, vt);
            chk("R1 reg ext", 64'(vx), 64'd0);
            chk("R1 reg tab", 64'(vt), 64'd0);
        end
        chk("R1 tb", tb_x, 64'd0);
        chk("R1 outs", {irqd_x, irqf_x, irqw_x, rq_x, irqd_t, irqf_t, irqw_t, rq_t}, 64'd0);
    endtask

    task automatic t_timebase;
        logic [63:0] s;
        s = tb_x;
        tick(5);
        chk("R11 advance", tb_x, s + 64'd5);
        repeat (3) @(negedge clk);
        chk("R11 hold", tb_x, s + 64'd5);
    endtask

    task automatic t_ctrl_mask;
        logic [31:0] vx, vt;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, vx, vt);
        chk("R10 ext mode ctrl", 64'(vx), 64'hFFDF_E000);
        chk("R10 table mode ctrl", 64'(vt), 64'hFFC0_0000);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_dec_oneshot;
        logic [31:0] vx, vt;
        wr(2'd0, 32'h0400_0000);
        wr(2'd2, 32'd3);
        tick(2);
        rd(2'd2, vx, vt);
        chk("R4 count", 64'(vx), 64'd1);
        chk("R4 no early irq", 64'(irqd_x), 64'd0);
        tick(1);
        rd(2'd2, vx, vt);
        chk("R4 zero", 64'(vx), 64'd0);
        chk("R4 irq at zero", 64'(irqd_x), 64'd1);
        tick(3);
        rd(2'd2, vx, vt);
        chk("R4 holds zero", 64'(vx), 64'd0);
        wr(2'd1, 32'h0800_0000);
        chk("R2 clear dis", 64'(irqd_x), 64'd0);
        tick(2);
        chk("R4 no further event", 64'(irqd_x), 64'd0);
    endtask

    task automatic t_irq_gate;
        wr(2'd2, 32'd1);
        tick(1);
        chk("R3 irq with enable", 64'(irqd_x), 64'd1);
        wr(2'd0, 32'h0);
        chk("R3 enable off", 64'(irqd_x), 64'd0);
        wr(2'd0, 32'h0400_0000);
        chk("R3 enable on again", 64'(irqd_x), 64'd1);
        wr(2'd1, 32'h0400_0000);
        chk("R2 zero bit kept", 64'(irqd_x), 64'd1);
        wr(2'd1, 32'h0800_0000);
        chk("R2 one bit cleared", 64'(irqd_x), 64'd0);
    endtask

    task automatic t_dec_reload;
        logic [31:0] vx, vt;
        wr(2'd0, 32'h0440_0000);
        wr(2'd3, 32'd5);
        wr(2'd2, 32'd2);
        tick(2);
        rd(2'd2, vx, vt);
        chk("R5 reloaded", 64'(vx), 64'd5);
        chk("R5 event flagged", 64'(irqd_x), 64'd1);
        tick(1);
        rd(2'd2, vx, vt);
        chk("R5 keeps counting", 64'(vx), 64'd4);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_fit_ext;
        int n;
        // fp=2, ext=1 -> tap bit 6 in extended mode; FIE set
        wr(2'd0, 32'h0280_2000);
        wr(2'd1, 32'h0400_0000);
        n = to_rise(tb_x, 6);
        tick(n - 1);
        chk("R6 fit not before edge", 64'(irqf_x), 64'd0);
        tick(1);
        chk("R6 fit on edge of bit 6", 64'(irqf_x), 64'd1);
    endtask

    task automatic t_fit_tab;
        int n;
        wr(2'd1, 32'h0400_0000);
        n = to_rise(tb_t, 4);
        tick(n - 1);
        chk("R7 table fit not before edge", 64'(irqf_t), 64'd0);
        tick(1);
        chk("R7 table fit on edge of bit 4", 64'(irqf_t), 64'd1);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_wdt;
        logic [31:0] vx, vt;
        // wp=1 ext=0 -> bit 1; reset control 2; watchdog irq enable
        wr(2'd0, 32'h6800_0000);
        wr(2'd1, 32'hFFFF_FFFF);
        tick(to_rise(tb_x, 1));
        rd(2'd1, vx, vt);
        chk("R8 first event arms", 64'(vx[31:28]), 64'h8);
        chk("R8 no irq yet", 64'(irqw_x), 64'd0);
        tick(to_rise(tb_x, 1));
        rd(2'd1, vx, vt);
        chk("R8 second event flags", 64'(vx[31:28]), 64'hC);
        chk("R8 irq_wdt", 64'(irqw_x), 64'd1);
        chk("R8 no reset yet", 64'(rq_x), 64'd0);
        tick(to_rise(tb_x, 1));
        chk("R8 reset request", 64'(rq_x), 64'd1);
        chk("R8 reset code", 64'(code_x), 64'd2);
        @(negedge clk);
        chk("R8 request one cycle", 64'(rq_x), 64'd0);
        chk("R8 code held", 64'(code_x), 64'd2);
    endtask

    task automatic t_wdt_nowrc;
        logic [31:0] vx, vt;
        wr(2'd0, 32'h4800_0000);
        wr(2'd1, 32'h3000_0000);
        tick(to_rise(tb_x, 1));
        chk("R9 no reset request", 64'(rq_x), 64'd0);
        rd(2'd1, vx, vt);
        chk("R9 status unchanged", 64'(vx[31:28]), 64'hC);
        chk("R9 code zero", 64'(code_x), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timebase();
        t_ctrl_mask();
        t_dec_oneshot();
        t_irq_gate();
        t_dec_reload();
        t_fit_ext();
        t_fit_tab();
        t_wdt();
        t_wdt_nowrc();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule